// File: doc/BRIEF.md
# Segmented dynamic-float feature decoder

This block sits between a memory read path and a distance datapath. It accepts one 64-bit burst word at a time, together with the burst's index within the vector, and unpacks the reduced-precision floating-point features packed in it into IEEE single-precision values. It emits them one per cycle under a valid/ready handshake.

Each feature has a sign bit, an exponent field of `nexp` bits and a mantissa field of `nman` bits. All features in one burst share a single format. Different burst-index ranges of the same vector may use different formats.

A small segment table maps burst indices to formats. Each of its entries holds an upper burst-index limit and a format. A burst takes the format of the lowest-numbered entry whose limit is at or above its index. Software loads the table through a single-cycle write port.

The control is a two-state machine:
- `ST_IDLE` accepts a burst. Its transition *ACCEPT* goes to `ST_EMIT` when `in_valid` is high.
- `ST_EMIT` presents features. Its transition *STEP* stays in `ST_EMIT` on a handshake that leaves features in the burst. Its transition *DONE* returns to `ST_IDLE` on the handshake of the final feature.

Top module: `seg_dfloat_decoder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. Every table entry has limit 255 and format nexp=8, nman=23, so each burst passes through as two unchanged 32-bit words.
- R2: Features are packed from bit 0 upward with width w = 1+nexp+nman. The burst yields floor(64/w) features. Bits above the last whole feature are ignored. Features are emitted lowest first.
- R3: A feature with a nonzero stored exponent e decodes to {sign, e - (2^(nexp-1)-1) + 127 as 8 bits, mantissa shifted left by 23-nman with zero fill}.
- R4: A feature whose stored exponent is 0 decodes to signed zero ({sign, 31'b0}), whatever its mantissa.
- R5: A burst with index i uses the format of the lowest-numbered entry whose limit is at or above i. If no entry matches, nexp=8 and nman=23 are used.
- R6: A table write is applied only if 2<=nexp<=8, 3<=nman<=23 and 12<=1+nexp+nman<=32. Any other write leaves the table unchanged.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `in_ready` and `out_valid` are never high together.
- R8: `out_last` is high only on the final feature of a burst accepted with `in_last`=1. After that feature's handshake the block returns to accepting bursts.
- R9: The format is fixed when the burst is accepted. A table write made while that burst is being emitted affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 3 | Table entry to write |
| cfg_limit | input | 8 | Highest burst index covered by the entry |
| cfg_nexp | input | 4 | Exponent field width |
| cfg_nman | input | 5 | Mantissa field width |
| in_valid | input | 1 | Burst word offered |
| in_ready | output | 1 | Decoder can take a burst |
| in_word | input | 64 | Packed burst |
| in_idx | input | 8 | Burst index within the vector |
| in_last | input | 1 | Burst is the last of the vector |
| out_valid | output | 1 | Decoded feature present |
| out_ready | input | 1 | Consumer takes the feature |
| out_data | output | 32 | Single-precision feature |
| out_last | output | 1 | Final feature of the vector |

## Verification
The embedded properties check the following on every cycle:
- the output holds while it is stalled;
- the two handshakes never overlap;
- the block returns to `ST_IDLE` after the last feature;
- the remaining-feature count stays in its legal range;
- a rejected table write leaves all entries untouched.

The bench scenarios are needed for the rest:
- the numeric conversion, zero flushing and feature counts for each width;
- the priority lookup over index ranges;
- the capture of the format at acceptance while the table is rewritten in mid-burst.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
    localparam int MIN_FW   = 12;
    localparam int MAX_FW   = 32;
    localparam int MIN_NEXP = 2;
    localparam int MAX_NEXP = 8;
    localparam int MIN_NMAN = 3;
    localparam int MAX_NMAN = 23;

    typedef struct packed {
        logic [3:0] nexp;
        logic [4:0] nman;
    } fmt_t;

    localparam fmt_t FMT_FP32 = '{nexp: 4'd8, nman: 5'd23};

    typedef enum logic {ST_IDLE, ST_EMIT} state_t;

    function automatic logic [5:0] fmt_width(fmt_t f);
        return 6'(1 + f.nexp + f.nman);
    endfunction

    function automatic logic fmt_ok(fmt_t f);
        int w;
        w = 1 + int'(f.nexp) + int'(f.nman);
        return (int'(f.nexp) >= MIN_NEXP) && (int'(f.nexp) <= MAX_NEXP) &&
               (int'(f.nman) >= MIN_NMAN) && (int'(f.nman) <= MAX_NMAN) &&
               (w >= MIN_FW) && (w <= MAX_FW);
    endfunction
endpackage

// File: rtl/dfd_fmt_table.sv
module dfd_fmt_table
    import dfd_pkg::*;
#(
    parameter int N_SEG = 8,
    parameter int IDX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(N_SEG)-1:0] cfg_sel,
    input  logic [IDX_W-1:0]         cfg_limit,
    input  fmt_t                     cfg_fmt,
    input  logic [IDX_W-1:0]         look_idx,
    output fmt_t                     look_fmt
);
    localparam int SEL_W = $clog2(N_SEG);
    localparam int ENT_W = IDX_W + $bits(fmt_t);

    logic [IDX_W-1:0]       lim_q [N_SEG];
    fmt_t                   fmt_q [N_SEG];
    logic [N_SEG-1:0]       hit;
    logic [N_SEG*ENT_W-1:0] tbl_flat;
    logic                   wr_ok;

    assign wr_ok = cfg_we && fmt_ok(cfg_fmt);

    for (genvar g = 0; g < N_SEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_q[g] <= '1;
                fmt_q[g] <= FMT_FP32;
            end else if (wr_ok && cfg_sel == SEL_W'(g)) begin
                lim_q[g] <= cfg_limit;
                fmt_q[g] <= cfg_fmt;
            end
        end
        assign hit[g] = (look_idx <= lim_q[g]);
        assign tbl_flat[g*ENT_W +: ENT_W] = {lim_q[g], fmt_q[g]};
    end

    // lowest-numbered matching entry wins
    always_comb begin
        look_fmt = FMT_FP32;
        for (int i = N_SEG - 1; i >= 0; i--) begin
            if (hit[i]) look_fmt = fmt_q[i];
        end
    end

    // R6
    bad_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !fmt_ok(cfg_fmt)) |=> $stable(tbl_flat));
endmodule

// File: rtl/dfd_convert.sv
module dfd_convert
    import dfd_pkg::*;
(
    input  logic [31:0] raw,
    input  fmt_t        fmt,
    output logic [31:0] fp
);
    int          nm;
    int          ne;
    logic [31:0] man;
    logic [31:0] ex;
    logic        sg;

    always_comb begin
        nm  = int'(fmt.nman);
        ne  = int'(fmt.nexp);
        man = raw & ((32'd1 << nm) - 32'd1);
        ex  = (raw >> nm) & ((32'd1 << ne) - 32'd1);
        sg  = raw[5'(nm + ne)];
        if (ex == 32'd0) begin
            fp = {sg, 31'd0};
        end else begin
            fp = {sg, 8'(ex + 32'd128 - (32'd1 << (ne - 1))), 23'(man << (23 - nm))};
        end
    end
endmodule

// File: rtl/seg_dfloat_decoder.sv
module seg_dfloat_decoder
    import dfd_pkg::*;
#(
    parameter int BURST_W = 64,
    parameter int IDX_W   = 8,
    parameter int N_SEG   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(N_SEG)-1:0] cfg_sel,
    input  logic [IDX_W-1:0]         cfg_limit,
    input  logic [3:0]               cfg_nexp,
    input  logic [4:0]               cfg_nman,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [BURST_W-1:0]       in_word,
    input  logic [IDX_W-1:0]         in_idx,
    input  logic                     in_last,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [31:0]              out_data,
    output logic                     out_last
);
    localparam int MAX_FEAT = BURST_W / MIN_FW;
    localparam int CNT_W    = $clog2(MAX_FEAT + 1);

    state_t              state_q, state_d;
    logic [BURST_W-1:0]  sh_q;
    fmt_t                fmt_q;
    fmt_t                look_fmt;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    nfeat;
    logic                vlast_q;
    int                  fw;

    dfd_fmt_table #(.N_SEG(N_SEG), .IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_limit(cfg_limit),
        .cfg_fmt  ('{nexp: cfg_nexp, nman: cfg_nman}),
        .look_idx (in_idx),
        .look_fmt (look_fmt)
    );

    dfd_convert u_cvt (
        .raw(sh_q[31:0]),
        .fmt(fmt_q),
        .fp (out_data)
    );

    assign nfeat = CNT_W'(BURST_W / int'(fmt_width(look_fmt)));
    assign fw    = int'(fmt_width(fmt_q));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: ACCEPT, STEP, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EMIT;
            ST_EMIT: if (out_ready && cnt_q == CNT_W'(1)) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_last  = (state_q == ST_EMIT) && vlast_q && (cnt_q == CNT_W'(1));
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            fmt_q   <= FMT_FP32;
            cnt_q   <= '0;
            vlast_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid) begin
                    sh_q    <= in_word;
                    fmt_q   <= look_fmt;
                    cnt_q   <= nfeat;
                    vlast_q <= in_last;
                end
                ST_EMIT: if (out_ready) begin
                    sh_q  <= sh_q >> fw;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            endcase
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> in_ready);

    // R2
    feat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_W'(MAX_FEAT)) && (!out_valid || cnt_q != '0));
endmodule

// File: tb/sim_seg_dfloat_decoder.sv
module sim_seg_dfloat_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_limit = '0;
    logic [3:0]  cfg_nexp = '0;
    logic [4:0]  cfg_nman = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_word = '0;
    logic [7:0]  in_idx = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;

    always #5 clk = ~clk;

    seg_dfloat_decoder u0 (.*);

    typedef struct {
        logic [31:0] data;
        logic        last;
        string       tag;
    } item_t;

    item_t q[$];
    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    done = 0;

    int m_lim[8];
    int m_ne[8];
    int m_nm[8];

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_fp(logic [31:0] f, int ne, int nm);
        logic [31:0] m;
        int          e;
        logic        s;
        m = f & ((32'd1 << nm) - 32'd1);
        e = int'((f >> nm) & ((32'd1 << ne) - 32'd1));
        s = f[ne + nm];
        if (e == 0) return {s, 31'd0};
        return {s, 8'(e - ((1 << (ne - 1)) - 1) + 127), 23'(m << (23 - nm))};
    endfunction

    task automatic cfg_write(int sel, int lim, int ne, int nm);
        int w;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_limit = 8'(lim);
        cfg_nexp = 4'(ne); cfg_nman = 5'(nm);
        @(negedge clk);
        cfg_we = 1'b0;
        w = 1 + ne + nm;
        if (ne >= 2 && ne <= 8 && nm >= 3 && nm <= 23 && w >= 12 && w <= 32) begin
            m_lim[sel] = lim; m_ne[sel] = ne; m_nm[sel] = nm;
        end
    endtask

    task automatic send_burst(logic [63:0] word, int idx, bit last, string tag);
        int    ne, nm, w, n;
        logic [31:0] f, mask;
        item_t it;
        ne = 8; nm = 23;
        for (int i = 7; i >= 0; i--) begin
            if (idx <= m_lim[i]) begin ne = m_ne[i]; nm = m_nm[i]; end
        end
        w = 1 + ne + nm;
        n = 64 / w;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_word = word; in_idx = 8'(idx); in_last = last;
        for (int k = 0; k < n; k++) begin
            f = 32'(word >> (k * w)) & mask;
            it.data = ref_fp(f, ne, nm);
            it.last = last && (k == n - 1);
            it.tag  = tag;
            q.push_back(it);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    logic [31:0] held_d;
    logic        held_l;
    bit          held_v = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = (cyc % 4 != 3);
            #1;
            if (rst_n) begin
                if (held_v && out_valid) begin
                    chk(out_data == held_d && out_last == held_l,
                        "R7 hold while stalled", out_data, held_d);
                end
                if (out_valid && in_ready) chk(0, "R7 overlap", 32'(in_ready), 32'd0);
                held_v = out_valid && !out_ready;
                held_d = out_data;
                held_l = out_last;
                if (out_valid && out_ready) begin
                    if (q.size() == 0) begin
                        chk(0, "R2 unexpected feature", out_data, 32'd0);
                    end else begin
                        item_t it;
                        it = q.pop_front();
                        chk(out_data == it.data, it.tag, out_data, it.data);
                        chk(out_last == it.last, {"R8 last flag / ", it.tag},
                            32'(out_last), 32'(it.last));
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
    function automatic logic [63:0] xs(logic [63:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) begin m_lim[i] = 255; m_ne[i] = 8; m_nm[i] = 23; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);

        // R1 default table passes 32-bit words through
        send_burst(64'hC0490FDB_3F800000, 5, 1, "R1 default passthrough");
        send_burst(64'h00000000_80000000, 200, 0, "R1 default zeros");

        // R5 program ranges: 0-1 half, 2-3 12-bit, 4-255 20-bit
        cfg_write(0, 1, 5, 10);
        cfg_write(1, 3, 4, 7);
        cfg_write(2, 255, 6, 13);
        // R6 invalid writes ignored
        cfg_write(0, 255, 9, 10);
        cfg_write(1, 255, 5, 2);
        cfg_write(2, 0, 8, 23 + 8);

        // R2 R3 half features, one vector of four bursts
        send_burst(64'hC500_3555_7BFF_3C00, 0, 0, "R3 16-bit rebias");
        send_burst(64'hABCD_1234_0400_4248, 1, 0, "R6 entry0 still 16-bit");
        send_burst(64'hF123_4567_89AB_CDEF, 2, 0, "R2 12-bit five features, high bits ignored");
        send_burst(64'hFFFF_F0F0_1234_5678, 3, 1, "R5 second entry range");
        send_burst(64'hFEDC_BA98_7654_3210, 4, 1, "R5 third entry 20-bit");
        // R4 zero exponent with nonzero mantissa and sign
        send_burst(64'h0000_83FF_8000_03FF, 1, 1, "R4 zero exponent flush");

        // R9 rewrite entry0 while burst in flight
        send_burst(64'h4000_3C00_C000_BC00, 0, 1, "R9 format captured at accept");
        cfg_write(0, 1, 8, 23);
        send_burst(64'h4049_0FDB_BF80_0000, 0, 1, "R9 new format afterwards");

        // R3 R5 pseudo-random mix
        for (int b = 0; b < 40; b++) begin
            rs = xs(rs);
            send_burst(rs, int'(rs[63:56]), (b % 4) == 3, "R3 random bursts");
        end

        for (int t = 0; t < 2000 && (q.size() != 0 || !in_ready); t++) @(negedge clk);
        chk(q.size() == 0, "R8 all features drained", 32'(q.size()), 32'd0);
        @(negedge clk);
        #2;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R8 idle after last",
            {30'd0, in_ready, out_valid}, 32'd2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule